// File: doc/BRIEF.md
# Quadrant Path-Set Decomposed Crossbar

This block is the switch stage of a two-dimensional mesh or torus router. Buffered flits are held in four quadrant path sets: north-east, south-east, south-west and north-west. Each path set holds three virtual-channel (VC) slots, one for each port that can feed that quadrant. Each cycle, a round-robin selector in every path set puts one slot forward.

The forwarded flit carries a direction bit that was chosen one hop earlier. The bit picks the vertical or the horizontal output of its quadrant. Each of the four outputs (N, E, S, W) can be reached from only two quadrants, and a two-input round-robin arbiter chooses between them, subject to downstream credit. This gives a crossbar with half the connections of a full 4x4 switch. Flits for the local node leave before this stage, so there is no local output.

The switch works as a wormhole switch. An output granted to a header flit stays with that packet until its tail passes. A grant pops the winning slot and returns a credit upstream in the same cycle. The flit then appears on a registered output one cycle later.

Top module: `quad_xbar`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every `out_valid` bit is 0.
- R2: Slot index is `quadrant*3 + vc`, with quadrants numbered NE=0, SE=1, SW=2, NW=3. Outputs are numbered N=0, E=1, S=2, W=3. With `in_horiz`=0 a flit goes to the vertical output of its quadrant (NE,NW to N; SE,SW to S). With `in_horiz`=1 it goes to the horizontal output (NE,SE to E; SW,NW to W).
- R3: Each path set puts forward at most one slot per cycle. It scans from a pointer that moves to the slot after the granted one only when a grant happens. With all three slots always full, grants go 0,1,2,0.
- R4: When two quadrants want the same free output, grants alternate between them. After reset the first grant goes to NW for N, NE for E, SE for S and SW for W.
- R5: An output whose `out_credit` bit is 0 grants nothing. Its waiting flit is neither popped nor forwarded until credit returns.
- R6: A grant raises exactly the winning slot's `vc_pop` bit in the same cycle. No bit rises for an empty slot.
- R7: A flit granted in cycle t appears on its output's `out_valid`, `out_kind` and `out_data` in cycle t+1.
- R8: Flit kind is a 2-bit code: bit0 marks a header and bit1 marks a tail (00 body, 01 header, 10 tail, 11 single-flit packet). From a header without a tail until the tail is granted, the output serves only that packet, and the path set serves only that slot.
- R9: Outputs fed by disjoint requests are granted in the same cycle, so up to four flits move per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 12 | Slot holds a flit, index quadrant*3+vc |
| in_kind | input | 24 | 2-bit flit kind per slot |
| in_data | input | 192 | 16-bit flit payload per slot |
| in_horiz | input | 12 | Pre-selected direction per slot: 1 horizontal, 0 vertical |
| out_credit | input | 4 | Downstream has room, per output N,E,S,W |
| vc_pop | output | 12 | Slot granted this cycle; doubles as credit return upstream |
| out_valid | output | 4 | Flit present on output N,E,S,W |
| out_kind | output | 8 | 2-bit kind per output |
| out_data | output | 64 | 16-bit payload per output |

## Verification
Single flits are sent from every quadrant with both direction bits. This separates a correct quadrant-to-output mapping from a mirrored or swapped one. Keeping all three slots of one path set full shows whether the pointer rotates fairly or sticks. Two quadrants aiming at one output show whether arbitration alternates. A multi-flit packet raced by a competing single flit, together with a second slot in the same path set, shows whether the output and path-set locks hold until the tail. Finally, a withheld credit and four disjoint requests show that credit gating works and that the outputs run in parallel.

// File: rtl/quad_xbar_pkg.sv
package quad_xbar_pkg;

    localparam int NUM_QUAD = 4;
    localparam int NUM_DIR  = 4;

    typedef enum logic [1:0] {
        QD_NE = 2'd0,
        QD_SE = 2'd1,
        QD_SW = 2'd2,
        QD_NW = 2'd3
    } quad_e;

    typedef enum logic [1:0] {
        DR_N = 2'd0,
        DR_E = 2'd1,
        DR_S = 2'd2,
        DR_W = 2'd3
    } dir_e;

    // bit0 = header, bit1 = tail
    typedef enum logic [1:0] {
        FK_BODY   = 2'b00,
        FK_HEAD   = 2'b01,
        FK_TAIL   = 2'b10,
        FK_SINGLE = 2'b11
    } fkind_e;

    // Output reached by quadrant q for the chosen axis.
    function automatic dir_e quad_target(input int q, input logic horiz);
        if (horiz)
            return (q == int'(QD_NE) || q == int'(QD_SE)) ? DR_E : DR_W;
        else
            return (q == int'(QD_NE) || q == int'(QD_NW)) ? DR_N : DR_S;
    endfunction

    // The two quadrants feeding output d: first-priority and second.
    function automatic int src_first(input int d);
        return (d + NUM_QUAD - 1) % NUM_QUAD;
    endfunction

    function automatic int src_second(input int d);
        return d;
    endfunction

endpackage

// File: rtl/quad_xbar_pathset.sv
module quad_xbar_pathset
    import quad_xbar_pkg::*;
#(
    parameter int VCS  = 3,
    parameter int DW   = 16,
    parameter int QID  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VCS-1:0]    vc_valid,
    input  logic [2*VCS-1:0]  vc_kind,
    input  logic [DW*VCS-1:0] vc_data,
    input  logic [VCS-1:0]    vc_horiz,
    input  logic              grant,
    output logic              req,
    output dir_e              dst,
    output logic [1:0]        kind,
    output logic [DW-1:0]     data,
    output logic [VCS-1:0]    pop
);

    localparam int SW = (VCS > 1) ? $clog2(VCS) : 1;

    logic [SW-1:0] ptr_q;
    logic          lock_q;
    logic [SW-1:0] lock_vc_q;
    dir_e          lock_dst_q;
    logic [SW-1:0] pick;
    logic [SW-1:0] sel;

    always_comb begin
        logic found;
        found = 1'b0;
        pick  = ptr_q;
        for (int i = 0; i < VCS; i++) begin
            int idx;
            idx = int'(ptr_q) + i;
            if (idx >= VCS) idx = idx - VCS;
            if (!found && vc_valid[idx]) begin
                pick  = SW'(idx);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        sel  = lock_q ? lock_vc_q : pick;
        req  = vc_valid[sel];
        dst  = lock_q ? lock_dst_q : quad_target(QID, vc_horiz[sel]);
        kind = vc_kind[sel*2 +: 2];
        data = vc_data[sel*DW +: DW];
        pop  = '0;
        if (grant) pop[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            lock_q     <= 1'b0;
            lock_vc_q  <= '0;
            lock_dst_q <= DR_N;
        end else if (grant) begin
            ptr_q      <= (int'(sel) == VCS - 1) ? '0 : sel + SW'(1);
            lock_q     <= ~kind[1];
            lock_vc_q  <= sel;
            lock_dst_q <= dst;
        end
    end

endmodule

// File: rtl/quad_xbar_outarb.sv
module quad_xbar_outarb (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic [1:0] tail,
    input  logic       credit,
    output logic [1:0] grant,
    output logic       win
);

    logic last_q;
    logic lock_q;
    logic owner_q;
    logic has;

    always_comb begin
        if (lock_q) begin
            win = owner_q;
            has = req[owner_q];
        end else begin
            win = req[~last_q] ? ~last_q : last_q;
            has = |req;
        end
        grant = '0;
        if (has && credit) grant[win] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= 1'b1;
            lock_q  <= 1'b0;
            owner_q <= 1'b0;
        end else if (|grant) begin
            last_q  <= win;
            lock_q  <= ~tail[win];
            owner_q <= win;
        end
    end

endmodule

// File: rtl/quad_xbar.sv
module quad_xbar
    import quad_xbar_pkg::*;
#(
    parameter int DW  = 16,
    parameter int VCS = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_QUAD*VCS-1:0]        in_valid,
    input  logic [2*NUM_QUAD*VCS-1:0]      in_kind,
    input  logic [DW*NUM_QUAD*VCS-1:0]     in_data,
    input  logic [NUM_QUAD*VCS-1:0]        in_horiz,
    input  logic [NUM_DIR-1:0]             out_credit,
    output logic [NUM_QUAD*VCS-1:0]        vc_pop,
    output logic [NUM_DIR-1:0]             out_valid,
    output logic [2*NUM_DIR-1:0]           out_kind,
    output logic [DW*NUM_DIR-1:0]          out_data
);

    logic          ps_req  [NUM_QUAD];
    dir_e          ps_dst  [NUM_QUAD];
    logic [1:0]    ps_kind [NUM_QUAD];
    logic [DW-1:0] ps_data [NUM_QUAD];
    logic          ps_gnt  [NUM_QUAD];
    logic [1:0]    od_gnt  [NUM_DIR];

    for (genvar q = 0; q < NUM_QUAD; q++) begin : g_set
        localparam int DN_FIRST  = (q + 1) % NUM_DIR;
        localparam int DN_SECOND = q;

        quad_xbar_pathset #(.VCS(VCS), .DW(DW), .QID(q)) u_set (
            .clk      (clk),
            .rst      (rst),
            .vc_valid (in_valid[q*VCS +: VCS]),
            .vc_kind  (in_kind[2*q*VCS +: 2*VCS]),
            .vc_data  (in_data[DW*q*VCS +: DW*VCS]),
            .vc_horiz (in_horiz[q*VCS +: VCS]),
            .grant    (ps_gnt[q]),
            .req      (ps_req[q]),
            .dst      (ps_dst[q]),
            .kind     (ps_kind[q]),
            .data     (ps_data[q]),
            .pop      (vc_pop[q*VCS +: VCS])
        );

        assign ps_gnt[q] = od_gnt[DN_FIRST][0] | od_gnt[DN_SECOND][1];
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_out
        localparam int SA = src_first(d);
        localparam int SB = src_second(d);

        logic [1:0]    req;
        logic [1:0]    tail;
        logic          win;
        logic          vld_q;
        logic [1:0]    kind_q;
        logic [DW-1:0] data_q;

        assign req[0]  = ps_req[SA] && (ps_dst[SA] == dir_e'(d));
        assign req[1]  = ps_req[SB] && (ps_dst[SB] == dir_e'(d));
        assign tail[0] = ps_kind[SA][1];
        assign tail[1] = ps_kind[SB][1];

        quad_xbar_outarb u_arb (
            .clk    (clk),
            .rst    (rst),
            .req    (req),
            .tail   (tail),
            .credit (out_credit[d]),
            .grant  (od_gnt[d]),
            .win    (win)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q  <= 1'b0;
                kind_q <= '0;
                data_q <= '0;
            end else begin
                vld_q <= |od_gnt[d];
                if (|od_gnt[d]) begin
                    kind_q <= win ? ps_kind[SB] : ps_kind[SA];
                    data_q <= win ? ps_data[SB] : ps_data[SA];
                end
            end
        end

        assign out_valid[d]            = vld_q;
        assign out_kind[2*d +: 2]      = kind_q;
        assign out_data[DW*d +: DW]    = data_q;
    end

endmodule

// File: rtl/quad_xbar_chk.sv
module quad_xbar_chk
    import quad_xbar_pkg::*;
#(
    parameter int DW  = 16,
    parameter int VCS = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_QUAD*VCS-1:0]    in_valid,
    input logic [NUM_DIR-1:0]         out_credit,
    input logic [NUM_QUAD*VCS-1:0]    vc_pop,
    input logic [NUM_DIR-1:0]         out_valid,
    input logic [2*NUM_DIR-1:0]       out_kind
);

    logic [NUM_DIR-1:0] open_q;

    always_ff @(posedge clk) begin
        if (rst) open_q <= '0;
        else begin
            for (int d = 0; d < NUM_DIR; d++) begin
                if (out_valid[d]) open_q[d] <= ~out_kind[2*d+1];
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (out_valid == '0)); // R1

    AST_POP_HAS_FLIT: assert property (@(posedge clk) disable iff (rst)
        ((vc_pop & ~in_valid) == '0)); // R6

    AST_FLIT_COUNT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(out_valid) == $countones($past(vc_pop)))); // R7

    for (genvar q = 0; q < NUM_QUAD; q++) begin : g_q
        AST_ONE_SLOT_PER_SET: assert property (@(posedge clk) disable iff (rst)
            $onehot0(vc_pop[q*VCS +: VCS])); // R3
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_d
        AST_CREDIT_HONOURED: assert property (@(posedge clk) disable iff (rst)
            out_valid[d] |-> $past(out_credit[d])); // R5
        AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (rst)
            (out_valid[d] && open_q[d]) |-> !out_kind[2*d]); // R8
    end

endmodule

bind quad_xbar quad_xbar_chk #(.DW(DW), .VCS(VCS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_credit (out_credit),
    .vc_pop     (vc_pop),
    .out_valid  (out_valid),
    .out_kind   (out_kind)
);

// File: tb/quad_xbar_test.sv
module quad_xbar_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NS = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NS-1:0]   in_valid = '0;
    logic [2*NS-1:0] in_kind = '0;
    logic [DW*NS-1:0] in_data = '0;
    logic [NS-1:0]   in_horiz = '0;
    logic [3:0]      out_credit = 4'hF;
    logic [NS-1:0]   vc_pop;
    logic [3:0]      out_valid;
    logic [7:0]      out_kind;
    logic [4*DW-1:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_xbar #(.DW(DW), .VCS(3)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_data(in_data), .in_horiz(in_horiz), .out_credit(out_credit),
        .vc_pop(vc_pop), .out_valid(out_valid), .out_kind(out_kind),
        .out_data(out_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        in_valid = '0; in_kind = '0; in_data = '0; in_horiz = '0;
        out_credit = 4'hF;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        clear_in();
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic put(input int idx, input logic [1:0] k, input logic [DW-1:0] d, input logic h);
        in_valid[idx] = 1'b1;
        in_kind[2*idx +: 2] = k;
        in_data[DW*idx +: DW] = d;
        in_horiz[idx] = h;
    endtask

    function automatic int exp_dir(input int q, input logic h);
        case ({q[1:0], h})
            3'b000: return 0; 3'b001: return 1;
            3'b010: return 2; 3'b011: return 1;
            3'b100: return 2; 3'b101: return 3;
            3'b110: return 0; default: return 3;
        endcase
    endfunction

    task automatic t_reset();
        do_reset();
        check("R1 out_valid after reset", 64'(out_valid), 64'h0);
        check("R1 vc_pop idle", 64'(vc_pop), 64'h0);
    endtask

    task automatic t_mapping();
        for (int q = 0; q < 4; q++) begin
            for (int h = 0; h < 2; h++) begin
                int d;
                do_reset();
                d = exp_dir(q, h[0]);
                put(q*3, 2'b11, DW'(16'h100 + q*2 + h), h[0]);
                #1;
                check("R6 pop same cycle", 64'(vc_pop), 64'(1) << (q*3));
                check("R7 no output in grant cycle", 64'(out_valid), 64'h0);
                tick();
                in_valid = '0;
                check("R2 output select", 64'(out_valid), 64'(1) << d);
                check("R2 output data", 64'(out_data[DW*d +: DW]), 64'(16'h100 + q*2 + h));
            end
        end
    endtask

    task automatic t_rotate();
        do_reset();
        for (int v = 0; v < 3; v++) put(v, 2'b11, DW'(16'h200 + v), 1'b1);
        for (int c = 0; c < 4; c++) begin
            #1;
            check("R3 rotation order", 64'(vc_pop), 64'(1) << (c % 3));
            tick();
            check("R7 rotated flit data", 64'(out_data[DW*1 +: DW]), 64'(16'h200 + (c % 3)));
        end
        in_valid = '0;
    endtask

    task automatic t_contend();
        do_reset();
        put(0, 2'b11, 16'hA0A0, 1'b1);
        put(3, 2'b11, 16'hB0B0, 1'b1);
        for (int c = 0; c < 4; c++) begin
            #1;
            check("R4 alternation pop", 64'(vc_pop), (c % 2 == 0) ? 64'h001 : 64'h008);
            tick();
            check("R4 alternation data", 64'(out_data[DW*1 +: DW]),
                  (c % 2 == 0) ? 64'hA0A0 : 64'hB0B0);
        end
        in_valid = '0;
    endtask

    task automatic t_credit();
        do_reset();
        put(0, 2'b11, 16'hC001, 1'b1);
        out_credit = 4'b1101;
        for (int c = 0; c < 2; c++) begin
            #1;
            check("R5 no pop without credit", 64'(vc_pop), 64'h0);
            tick();
            check("R5 no output without credit", 64'(out_valid), 64'h0);
        end
        out_credit = 4'hF;
        #1;
        check("R5 pop after credit", 64'(vc_pop), 64'h001);
        tick();
        in_valid = '0;
        check("R5 output after credit", 64'(out_valid), 64'h2);
        check("R5 data after credit", 64'(out_data[DW*1 +: DW]), 64'hC001);
    endtask

    task automatic t_worm();
        do_reset();
        put(0, 2'b01, 16'hD000, 1'b1);
        put(3, 2'b11, 16'hE000, 1'b1);
        put(1, 2'b11, 16'hF000, 1'b0);
        #1;
        check("R8 header granted", 64'(vc_pop), 64'h001);
        tick();
        check("R8 header out kind", 64'(out_kind[3:2]), 64'h1);
        put(0, 2'b00, 16'hD001, 1'b1);
        #1;
        check("R8 body holds output and set", 64'(vc_pop), 64'h001);
        tick();
        check("R8 body out data", 64'(out_data[DW*1 +: DW]), 64'hD001);
        put(0, 2'b10, 16'hD002, 1'b1);
        #1;
        check("R8 tail holds output", 64'(vc_pop), 64'h001);
        tick();
        check("R8 tail out kind", 64'(out_kind[3:2]), 64'h2);
        in_valid[0] = 1'b0;
        #1;
        check("R8 release after tail", 64'(vc_pop), 64'h00A);
        tick();
        in_valid = '0;
        check("R8 waiting flits out", 64'(out_valid), 64'h3);
        check("R8 waiting E data", 64'(out_data[DW*1 +: DW]), 64'hE000);
        check("R8 waiting N data", 64'(out_data[DW*0 +: DW]), 64'hF000);
    endtask

    task automatic t_parallel();
        do_reset();
        put(2, 2'b11, 16'h1111, 1'b0);
        put(3, 2'b11, 16'h2222, 1'b1);
        put(7, 2'b11, 16'h3333, 1'b0);
        put(11, 2'b11, 16'h4444, 1'b1);
        #1;
        check("R9 four pops", 64'(vc_pop), 64'h88C);
        tick();
        in_valid = '0;
        check("R9 four outputs", 64'(out_valid), 64'hF);
        check("R9 all data", 64'(out_data), 64'h4444_3333_2222_1111);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_mapping();
        t_rotate();
        t_contend();
        t_credit();
        t_worm();
        t_parallel();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule